// File: doc/BRIEF.md
# Cell-Replicating Shared-Buffer Switch

This block is a small shared-buffer cell switch with `N_PORTS` inputs and `N_PORTS` outputs. Each arriving cell carries a destination bitmap. A copy stage in front of the buffer expands the cell into one independent copy per set bit. Each copy takes its own buffer slot from a free list, and the slot address goes into the address queue of that copy's output. Once written, a copy is treated exactly like a unicast cell. No reference count links it to its siblings.

A multicast burst can ask for up to `N_PORTS` squared writes in one cycle, while the outputs can remove only `N_PORTS` cells per cycle. The block meets this demand by serializing. A single copy engine writes one copy per clock, lowest destination first, and holds its inputs off until the current cell is fully expanded.

When the free list runs dry in the middle of an expansion, the copies not yet written are discarded and added to a drop counter. Each output pops its queue whenever it has a cell and the output is ready. The cell is read and its slot goes back to the free list in the same cycle.

Top module: `csw_top`

## Requirements
- R1: While the copy engine is idle, exactly the lowest-numbered input with `in_valid` high sees `in_ready` high; all other inputs see it low, and at most one `in_ready` bit is ever high.
- R2: A cell accepted with k destination bits set produces its copies on the k clock edges after acceptance, one per edge, lowest output index first. `in_ready` stays low for all inputs until the last copy is written, so the next cell can be accepted no earlier than k+1 edges after the previous one.
- R3: Every copy occupies its own buffer slot; all `DEPTH` slots can hold distinct copies at the same time and each is delivered with its own contents intact.
- R4: Each output delivers the copies destined for it in the order their cells were accepted.
- R5: `out_valid[j]` is high exactly when output j has a queued copy, and `out_data` slice j shows that copy's data; a copy is removed when `out_valid[j]` and `out_ready[j]` are both high at a clock edge, and all outputs may remove a copy on the same edge.
- R6: A removed copy's slot returns to the free list on the same edge, so after draining, the full `DEPTH` slots can be filled again without loss.
- R7: If no slot is free when a copy is due, that copy and all remaining copies of the cell are dropped, `drop_count` rises by their number, and the engine becomes idle on that edge (m copies written then a drop gives an acceptance gap of m+2 edges). Copies already written are still delivered.
- R8: A cell whose bitmap is all zeros is accepted, stores nothing, delivers nothing and leaves `drop_count` unchanged.
- R9: After reset all outputs are idle, `drop_count` is 0, every slot is free and no input is ready unless it is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Cell offered on each input |
| in_bitmap | input | N_PORTS*N_PORTS | Destination bitmap; bit p*N_PORTS+j set means input p's cell goes to output j |
| in_data | input | N_PORTS*DATA_W | Cell payload per input, input p in bits p*DATA_W upward |
| in_ready | output | N_PORTS | Input p's cell is taken on this edge |
| out_valid | output | N_PORTS | Output has a queued copy |
| out_ready | input | N_PORTS | Output removes its head copy on this edge |
| out_data | output | N_PORTS*DATA_W | Head copy payload per output |
| drop_count | output | DROP_W | Copies discarded for lack of a free slot (wraps) |

## Verification
The bench sweeps every destination bitmap from every input, including the all-zero one. It measures the spacing between back-to-back acceptances; a design that pipelined wrongly or released the input early would show a gap other than k+1. It fills the buffer to a few free slots and then offers a wide multicast. A design that dropped the wrong ports, dropped the whole cell, or miscounted would deliver copies to the wrong outputs or show the wrong `drop_count`. It also fills all slots twice in a row, draining every output on the same edges. A design that leaked slots on concurrent frees, or shared one slot between copies, would drop cells on the second fill or deliver corrupted data.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

   // Index of the single set bit in a one-hot vector (0 when empty).
   function automatic int unsigned oh_index(input logic [63:0] oh);
      int unsigned idx;
      idx = 0;
      for (int i = 0; i < 64; i++) begin
         if (oh[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/csw_freelist.sv
`timescale 1ns/1ps
module csw_freelist #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc,
   input  logic [DEPTH-1:0]         free_vec,
   output logic                     avail,
   output logic [$clog2(DEPTH)-1:0] alloc_addr,
   output logic [DEPTH-1:0]         free_mask
);
   import csw_pkg::*;

   localparam int AW = $clog2(DEPTH);

   logic [DEPTH-1:0] low_oh;

   always_comb begin
      low_oh     = free_mask & (~free_mask + DEPTH'(1));
      avail      = |free_mask;
      alloc_addr = AW'(oh_index(64'(low_oh)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_mask <= '1;
      end else begin
         free_mask <= (free_mask & ~(alloc ? low_oh : '0)) | free_vec;
      end
   end

endmodule

// File: rtl/csw_addr_fifo.sv
`timescale 1ns/1ps
module csw_addr_fifo #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [$clog2(DEPTH)-1:0] push_addr,
   input  logic                     pop,
   output logic [$clog2(DEPTH)-1:0] head,
   output logic                     not_empty,
   output logic [$clog2(DEPTH):0]   occ
);
   localparam int AW = $clog2(DEPTH);

   logic [AW-1:0] slots [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;

   always_ff @(posedge clk) begin
      if (push) slots[wp] <= push_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         occ <= '0;
      end else begin
         wp  <= wp + AW'(push);
         rp  <= rp + AW'(pop);
         occ <= occ + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   always_comb begin
      head      = slots[rp];
      not_empty = (occ != '0);
   end

endmodule

// File: rtl/csw_replicator.sv
`timescale 1ns/1ps
module csw_replicator #(
   parameter int N      = 4,
   parameter int W      = 8,
   parameter int DROP_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        in_valid,
   input  logic [N*N-1:0]      in_bitmap,
   input  logic [N*W-1:0]      in_data,
   output logic [N-1:0]        in_ready,
   input  logic                avail,
   output logic                copy_en,
   output logic [N-1:0]        copy_oh,
   output logic [W-1:0]        cell_data,
   output logic                busy,
   output logic [DROP_W-1:0]   drop_count
);
   logic [N-1:0] remain;
   logic [N-1:0] gnt_oh;
   logic [N-1:0] dest_oh;
   logic [N-1:0] sel_bm;
   logic [W-1:0] sel_data;
   logic         accept;

   always_comb begin
      gnt_oh   = in_valid & (~in_valid + N'(1));
      busy     = |remain;
      accept   = !busy && (|in_valid);
      in_ready = busy ? '0 : gnt_oh;
      sel_bm   = '0;
      sel_data = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_oh[i]) begin
            sel_bm   = in_bitmap[i*N +: N];
            sel_data = in_data[i*W +: W];
         end
      end
      dest_oh = remain & (~remain + N'(1));
      copy_en = busy && avail;
      copy_oh = copy_en ? dest_oh : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain     <= '0;
         cell_data  <= '0;
         drop_count <= '0;
      end else if (accept) begin
         remain    <= sel_bm;
         cell_data <= sel_data;
      end else if (busy) begin
         if (avail) begin
            remain <= remain & ~dest_oh;
         end else begin
            drop_count <= drop_count + DROP_W'($countones(remain));
            remain     <= '0;
         end
      end
   end

endmodule

// File: rtl/csw_top.sv
`timescale 1ns/1ps
module csw_top #(
   parameter int N_PORTS = 4,
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 8,
   parameter int DROP_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          in_valid,
   input  logic [N_PORTS*N_PORTS-1:0]  in_bitmap,
   input  logic [N_PORTS*DATA_W-1:0]   in_data,
   output logic [N_PORTS-1:0]          in_ready,
   output logic [N_PORTS-1:0]          out_valid,
   input  logic [N_PORTS-1:0]          out_ready,
   output logic [N_PORTS*DATA_W-1:0]   out_data,
   output logic [DROP_W-1:0]           drop_count
);
   localparam int AW = $clog2(DEPTH);
   localparam int OW = AW + 1;

   initial begin
      assert (N_PORTS >= 2 && N_PORTS <= 16)
         else $error("csw_top: N_PORTS out of range");
      assert (DEPTH >= N_PORTS && DEPTH <= 64 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("csw_top: DEPTH must be a power of two in [N_PORTS, 64]");
      assert (DATA_W >= 1 && DROP_W >= 1)
         else $error("csw_top: widths must be positive");
   end

   logic                 avail;
   logic [AW-1:0]        alloc_addr;
   logic [DEPTH-1:0]     free_mask;
   logic [DEPTH-1:0]     free_vec;
   logic                 copy_en;
   logic [N_PORTS-1:0]   copy_oh;
   logic [DATA_W-1:0]    cell_data;
   logic                 busy;
   logic [N_PORTS-1:0]   pop;
   logic [AW-1:0]        head_a [N_PORTS];
   logic [N_PORTS*OW-1:0] occ_flat;

   logic [DATA_W-1:0]    cell_mem [DEPTH];

   csw_replicator #(
      .N      (N_PORTS),
      .W      (DATA_W),
      .DROP_W (DROP_W)
   ) u_rep (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_bitmap  (in_bitmap),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .avail      (avail),
      .copy_en    (copy_en),
      .copy_oh    (copy_oh),
      .cell_data  (cell_data),
      .busy       (busy),
      .drop_count (drop_count)
   );

   csw_freelist #(
      .DEPTH (DEPTH)
   ) u_free (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (copy_en),
      .free_vec   (free_vec),
      .avail      (avail),
      .alloc_addr (alloc_addr),
      .free_mask  (free_mask)
   );

   always_ff @(posedge clk) begin
      if (copy_en) cell_mem[alloc_addr] <= cell_data;
   end

   generate
      for (genvar j = 0; j < N_PORTS; j++) begin : g_out
         logic [AW-1:0] head;
         logic          ne;
         logic [OW-1:0] occ;

         csw_addr_fifo #(
            .DEPTH (DEPTH)
         ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (copy_oh[j]),
            .push_addr (alloc_addr),
            .pop       (pop[j]),
            .head      (head),
            .not_empty (ne),
            .occ       (occ)
         );

         assign out_valid[j]              = ne;
         assign pop[j]                    = ne & out_ready[j];
         assign head_a[j]                 = head;
         assign out_data[j*DATA_W +: DATA_W] = cell_mem[head];
         assign occ_flat[j*OW +: OW]      = occ;
      end
   endgenerate

   always_comb begin
      free_vec = '0;
      for (int j = 0; j < N_PORTS; j++) begin
         if (pop[j]) free_vec[head_a[j]] = 1'b1;
      end
   end

endmodule

// File: rtl/csw_chk.sv
`timescale 1ns/1ps
module csw_chk #(
   parameter int N      = 4,
   parameter int DEPTH  = 16,
   parameter int AW     = 4,
   parameter int DROP_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N-1:0]          in_ready,
   input logic                  busy,
   input logic [N-1:0]          copy_oh,
   input logic [DEPTH-1:0]      free_mask,
   input logic [N*(AW+1)-1:0]   occ_flat,
   input logic [DROP_W-1:0]     drop_count
);
   int held;

   always_comb begin
      held = 0;
      for (int j = 0; j < N; j++) held += int'(occ_flat[j*(AW+1) +: AW+1]);
   end

   a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (in_ready == '0));

   a_r2_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(copy_oh));

   // R3 and R6: every slot is either free or held by exactly one queue entry
   a_r3_slot_conservation: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(free_mask) + held) == DEPTH);

   a_r7_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> ($past(free_mask) == '0));

   generate
      for (genvar j = 0; j < N; j++) begin : g_q
         a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            copy_oh[j] |-> (occ_flat[j*(AW+1) +: AW+1] < (AW+1)'(DEPTH)));
      end
   endgenerate

endmodule

bind csw_top csw_chk #(
   .N      (N_PORTS),
   .DEPTH  (DEPTH),
   .AW     (AW),
   .DROP_W (DROP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .busy       (busy),
   .copy_oh    (copy_oh),
   .free_mask  (free_mask),
   .occ_flat   (occ_flat),
   .drop_count (drop_count)
);

// File: tb/tb_csw_top.sv
`timescale 1ns/1ps
module tb_csw_top;
   localparam int NP = 4;
   localparam int DP = 16;
   localparam int W  = 8;
   localparam int DW = 16;

   logic              clk = 0;
   logic              rst_n;
   logic [NP-1:0]     in_valid;
   logic [NP*NP-1:0]  in_bitmap;
   logic [NP*W-1:0]   in_data;
   logic [NP-1:0]     in_ready;
   logic [NP-1:0]     out_valid;
   logic [NP-1:0]     out_ready;
   logic [NP*W-1:0]   out_data;
   logic [DW-1:0]     drop_count;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int exp_drop = 0;
   logic [7:0] seq = 8'd1;
   logic [7:0] mq [NP][$];

   csw_top #(.N_PORTS(NP), .DEPTH(DP), .DATA_W(W), .DROP_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bitmap(in_bitmap),
      .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .drop_count(drop_count)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int held_total();
      int s = 0;
      for (int j = 0; j < NP; j++) s += mq[j].size();
      return s;
   endfunction

   task automatic model_accept(input logic [3:0] b, input logic [7:0] d);
      int fc = DP - held_total();
      bit out = 0;
      for (int j = 0; j < NP; j++) begin
         if (b[j]) begin
            if (!out && fc > 0) begin
               mq[j].push_back(d);
               fc--;
            end else begin
               out = 1;
               exp_drop++;
            end
         end
      end
   endtask

   task automatic send(input int p, input logic [3:0] b, output int acc);
      logic [7:0] d = seq;
      seq = seq + 8'd1;
      @(negedge clk);
      in_valid[p] = 1'b1;
      in_bitmap[p*NP +: NP] = b;
      in_data[p*W +: W] = d;
      #1;
      while (!in_ready[p]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      acc = cyc;
      model_accept(b, d);
      #1 in_valid[p] = 1'b0;
   endtask

   task automatic settle();
      repeat (NP + 3) @(negedge clk);
   endtask

   task automatic drain_all(input string req);
      for (int guard = 0; guard < 100; guard++) begin
         bit any = 0;
         @(negedge clk);
         #1;
         for (int j = 0; j < NP; j++) begin
            bit ev = (mq[j].size() > 0);
            chk(out_valid[j] == ev, req, int'(out_valid[j]), int'(ev));
            if (ev) chk(out_data[j*W +: W] == mq[j][0], req,
                        int'(out_data[j*W +: W]), int'(mq[j][0]));
            any |= ev;
         end
         if (!any) break;
         out_ready = '1;
         @(posedge clk);
         #1;
         for (int j = 0; j < NP; j++) if (mq[j].size() > 0) void'(mq[j].pop_front());
         out_ready = '0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int a1, a2;
      rst_n = 0; in_valid = '0; in_bitmap = '0; in_data = '0; out_ready = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      chk(out_valid == '0, "R9 out_valid", int'(out_valid), 0);
      chk(drop_count == '0, "R9 drop_count", int'(drop_count), 0);
      chk(in_ready == '0, "R9 in_ready", int'(in_ready), 0);
      rst_n = 1;
      @(negedge clk);
      chk(out_valid == '0, "R9 idle after release", int'(out_valid), 0);

      // R1: lowest valid input is granted
      in_valid = 4'b1010; #1;
      chk(in_ready == 4'b0010, "R1 grant", int'(in_ready), 2);
      in_valid = 4'b1011; #1;
      chk(in_ready == 4'b0001, "R1 grant", int'(in_ready), 1);
      in_valid = 4'b1000; #1;
      chk(in_ready == 4'b1000, "R1 grant", int'(in_ready), 8);
      in_valid = '0; #1;
      chk(in_ready == '0, "R1 no valid", int'(in_ready), 0);

      // R2 R4 R5 R8: every bitmap from every input, gap measured back to back
      for (int p = 0; p < NP; p++) begin
         for (int b = 0; b < 16; b++) begin
            send(p, 4'(b), a1);
            send((p + 1) % NP, 4'b0000, a2);
            chk((a2 - a1) == $countones(4'(b)) + 1, "R2 accept gap",
                a2 - a1, $countones(4'(b)) + 1);
            settle();
            drain_all("R5 delivery");
         end
      end
      chk(drop_count == 0, "R8 no drops", int'(drop_count), 0);

      // R4: ordering across several cells per output
      send(0, 4'b0101, a1);
      send(1, 4'b0111, a1);
      send(2, 4'b1100, a1);
      send(3, 4'b1111, a1);
      settle();
      drain_all("R4 order");

      // R7: exhaust the free list partway through a cell
      send(0, 4'b1111, a1);
      send(1, 4'b1111, a1);
      send(2, 4'b1111, a1);
      send(3, 4'b0111, a1);
      send(2, 4'b1011, a1);
      send(3, 4'b0000, a2);
      chk((a2 - a1) == 3, "R7 gap after drop", a2 - a1, 3);
      settle();
      chk(int'(drop_count) == exp_drop, "R7 drop count", int'(drop_count), exp_drop);
      chk(exp_drop == 2, "R7 expected drops", exp_drop, 2);
      drain_all("R7 written copies kept");

      // R3 R6: fill all slots twice, concurrent drains in between
      for (int r = 0; r < 2; r++) begin
         for (int p = 0; p < NP; p++) send(p, 4'b1111, a1);
         settle();
         chk(int'(drop_count) == exp_drop, "R6 no loss on refill",
             int'(drop_count), exp_drop);
         chk(out_valid == 4'b1111, "R3 all outputs hold", int'(out_valid), 15);
         drain_all("R3 distinct slots");
      end
      for (int p = 0; p < NP; p++) send(p, 4'b1111, a1);
      send(0, 4'b0001, a1);
      settle();
      chk(int'(drop_count) == exp_drop, "R7 full buffer drop", int'(drop_count), exp_drop);
      drain_all("R6 drain after full");
      chk(out_valid == '0, "R6 empty at end", int'(out_valid), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule